// File: doc/BRIEF.md
# Transactional Private-Store Filter with Commit Log

This block sits next to a core's speculative data cache in a transactional memory that buffers writes until commit and detects conflicts at commit time. Every transactional access is classified as thread-private or shared. An access is private when the protection field from the address translation carries a locality flag, or when its word address lies inside the stack window of the running transaction. Private accesses mark the addressed cache word with a speculative-local bit. Shared stores are appended, address and data, to an in-order commit log. Stores to a word whose speculative-local bit is already set never enter the log.

On a commit request the log is drained onto a bus-side port one entry per valid/ready handshake, in the order the stores arrived. After the log is empty, all speculative-local bits are cleared in a single cycle. That clear is the whole commit of the private data and takes no bus cycles. A one-cycle done pulse follows. An abort empties the log and clears every speculative-local bit at once. While a commit is in progress, new accesses are not accepted.

Top module: `txpf_store_filter`

## Requirements
- R1: After reset, bus_valid, commit_done and q_overflow are 0 and every speculative-local bit reads 0 on sl_probe.
- R2: An access whose acc_prot bit 21 is 1 is private: acc_private is 1 while it is presented, it sets the speculative-local bit of its word, and as a store it is not logged.
- R3: The stack window is loaded from win_lo and win_hi by a one-cycle win_we strobe. An access is private when its word address (addr[31:2]) satisfies lo <= addr < hi, lower bound inclusive and upper bound exclusive.
- R4: Speculative-local state is held per 32-bit word, indexed by addr[7:2] (64 words). Marking one word leaves its neighbours in the same line unmarked.
- R5: A store classified as shared is still kept out of the log when its word's speculative-local bit is already set.
- R6: On commit the logged stores appear on bus_addr/bus_data in store order, one per cycle with bus_valid and bus_ready both 1. While bus_ready is 0, bus_valid stays 1 and the address and data hold steady.
- R7: The log holds 8 entries. A shared store that arrives when the log is full is not logged and sets q_overflow. q_overflow stays set until the commit completes or an abort occurs, and the first 8 entries are replayed unchanged.
- R8: Once the log has drained, one cycle clears all speculative-local bits. commit_done then goes high for exactly one cycle with q_overflow at 0. Private stores cause no bus transfers.
- R9: abort_req empties the log, clears all speculative-local bits and q_overflow in one cycle. A later commit makes no bus transfers.
- R10: Accesses presented while a commit is in progress are ignored: they enter neither the log nor the speculative-local bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_we | input | 1 | Loads the stack window bounds |
| win_lo | input | 32 | Stack window lower byte address (inclusive) |
| win_hi | input | 32 | Stack window upper byte address (exclusive) |
| acc_valid | input | 1 | Transactional access present |
| acc_store | input | 1 | 1 for a store, 0 for a load |
| acc_addr | input | 32 | Access byte address |
| acc_data | input | 32 | Store data |
| acc_prot | input | 32 | Protection field of the page, bit 21 = locality flag |
| acc_private | output | 1 | Current access classified as thread-private |
| sl_probe_addr | input | 32 | Address whose speculative-local bit is read |
| sl_probe | output | 1 | Speculative-local bit of sl_probe_addr's word |
| commit_req | input | 1 | Starts a commit |
| abort_req | input | 1 | Aborts the transaction |
| bus_valid | output | 1 | Replayed store on the bus port |
| bus_addr | output | 32 | Replayed store address |
| bus_data | output | 32 | Replayed store data |
| bus_ready | input | 1 | Bus accepts the replayed store |
| commit_done | output | 1 | One-cycle pulse at commit completion |
| q_overflow | output | 1 | A shared store found the log full |

## Verification
A wrong log pointer or count shows up at the bus port on the next commit as a missing, repeated or reordered transfer, or as a transfer of data that was never stored. It can stay hidden until that commit, so each scenario ends with a full drain. A wrong speculative-local bit is visible at once through sl_probe. It also shows up indirectly when a later shared store to the same word is wrongly kept out of, or let into, the log. A control-state error appears as a missing or doubled done pulse, or as accesses being accepted during a drain, within a few cycles of the commit request.

// File: rtl/txpf_pkg.sv
package txpf_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DRAIN = 2'd1,
        PH_CLEAR = 2'd2
    } txpf_phase_e;

    typedef struct packed {
        txpf_phase_e phase;
        logic        ovf;
        logic        done;
    } txpf_ctl_t;

endpackage

// File: rtl/txpf_classify.sv
module txpf_classify #(
    parameter int ADDR_W    = 32,
    parameter int PROT_W    = 32,
    parameter int LOCAL_BIT = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_we,
    input  logic [ADDR_W-1:0] win_lo,
    input  logic [ADDR_W-1:0] win_hi,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [PROT_W-1:0] acc_prot,
    output logic              is_private
);
    localparam int WA_W = ADDR_W - 2;

    typedef struct packed {
        logic [WA_W-1:0] lo;
        logic [WA_W-1:0] hi;
    } win_t;

    win_t win_d, win_q;
    logic [WA_W-1:0] word_addr;
    logic page_local, in_window;
    logic unused_bits;

    always_comb begin
        win_d = win_q;
        if (win_we) begin
            win_d.lo = win_lo[ADDR_W-1:2];
            win_d.hi = win_hi[ADDR_W-1:2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign word_addr  = acc_addr[ADDR_W-1:2];
    assign page_local = acc_prot[LOCAL_BIT];
    assign in_window  = (word_addr >= win_q.lo) && (word_addr < win_q.hi);
    assign is_private = page_local | in_window;

    // byte offsets and the other protection bits play no part in the decision
    assign unused_bits = ^{acc_addr[1:0], win_lo[1:0], win_hi[1:0], acc_prot};

    // R3: a strobe makes the presented bounds the active window
    assert_window_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        win_we |=> (win_q.lo == $past(win_lo[ADDR_W-1:2])) && (win_q.hi == $past(win_hi[ADDR_W-1:2])));

endmodule

// File: rtl/txpf_slbits.sv
module txpf_slbits #(
    parameter int NUM_WORDS = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         set_en,
    input  logic [$clog2(NUM_WORDS)-1:0] set_idx,
    input  logic                         clr_all,
    input  logic [$clog2(NUM_WORDS)-1:0] idx_a,
    input  logic [$clog2(NUM_WORDS)-1:0] idx_b,
    output logic                         bit_a,
    output logic                         bit_b,
    output logic                         any_set
);
    logic [NUM_WORDS-1:0] sl_d, sl_q;

    always_comb begin
        sl_d = sl_q;
        if (clr_all)     sl_d = '0;
        else if (set_en) sl_d[set_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sl_q <= '0;
        else        sl_q <= sl_d;
    end

    assign bit_a   = sl_q[idx_a];
    assign bit_b   = sl_q[idx_b];
    assign any_set = |sl_q;

    // R4: one marking touches a single word only
    assert_one_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !clr_all) |=> ($countones(sl_q) <= $past($countones(sl_q)) + 1));

    // R8: a clear leaves no marked word behind
    assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (sl_q == '0));

endmodule

// File: rtl/txpf_cqueue.sv
module txpf_cqueue #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              flush,
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data,
    output logic              empty,
    output logic              full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int ENT_W = ADDR_W + DATA_W;

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } ptrs_t;

    ptrs_t ptr_d, ptr_q;
    logic [ENT_W-1:0] mem_d [DEPTH];
    logic [ENT_W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    assign empty   = (ptr_q.cnt == '0);
    assign full    = (ptr_q.cnt == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        ptr_d = ptr_q;
        mem_d = mem_q;
        if (flush) begin
            ptr_d = '0;
        end else begin
            if (do_push) begin
                mem_d[ptr_q.wp] = {push_addr, push_data};
                ptr_d.wp = bump(ptr_q.wp);
            end
            if (do_pop) ptr_d.rp = bump(ptr_q.rp);
            case ({do_push, do_pop})
                2'b10:   ptr_d.cnt = ptr_q.cnt + 1'b1;
                2'b01:   ptr_d.cnt = ptr_q.cnt - 1'b1;
                default: ptr_d.cnt = ptr_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign head_addr = mem_q[ptr_q.rp][ENT_W-1:DATA_W];
    assign head_data = mem_q[ptr_q.rp][DATA_W-1:0];

    // R7: the filter never offers a store to a full log
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R6: occupancy stays within the storage
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q.cnt <= CNT_W'(DEPTH));

endmodule

// File: rtl/txpf_store_filter.sv
module txpf_store_filter
    import txpf_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int PROT_W    = 32,
    parameter int LOCAL_BIT = 21,
    parameter int NUM_WORDS = 64,
    parameter int Q_DEPTH   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_we,
    input  logic [ADDR_W-1:0] win_lo,
    input  logic [ADDR_W-1:0] win_hi,
    input  logic              acc_valid,
    input  logic              acc_store,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_data,
    input  logic [PROT_W-1:0] acc_prot,
    output logic              acc_private,
    input  logic [ADDR_W-1:0] sl_probe_addr,
    output logic              sl_probe,
    input  logic              commit_req,
    input  logic              abort_req,
    output logic              bus_valid,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data,
    input  logic              bus_ready,
    output logic              commit_done,
    output logic              q_overflow
);
    localparam int IDX_W = $clog2(NUM_WORDS);

    txpf_ctl_t ctl_d, ctl_q;

    logic [IDX_W-1:0] acc_idx, probe_idx;
    logic cls_private, sl_at_acc, sl_any;
    logic accept, local_hit, q_push, q_pop, q_empty, q_full, sl_set, sl_clr;
    logic unused_probe;

    assign acc_idx      = acc_addr[IDX_W+1:2];
    assign probe_idx    = sl_probe_addr[IDX_W+1:2];
    assign unused_probe = ^sl_probe_addr;

    txpf_classify #(
        .ADDR_W(ADDR_W), .PROT_W(PROT_W), .LOCAL_BIT(LOCAL_BIT)
    ) cls_i (
        .clk(clk), .rst_n(rst_n),
        .win_we(win_we), .win_lo(win_lo), .win_hi(win_hi),
        .acc_addr(acc_addr), .acc_prot(acc_prot),
        .is_private(cls_private)
    );

    txpf_slbits #(.NUM_WORDS(NUM_WORDS)) sl_i (
        .clk(clk), .rst_n(rst_n),
        .set_en(sl_set), .set_idx(acc_idx), .clr_all(sl_clr),
        .idx_a(acc_idx), .idx_b(probe_idx),
        .bit_a(sl_at_acc), .bit_b(sl_probe), .any_set(sl_any)
    );

    txpf_cqueue #(.DEPTH(Q_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) q_i (
        .clk(clk), .rst_n(rst_n),
        .push(q_push), .push_addr(acc_addr), .push_data(acc_data),
        .pop(q_pop), .flush(abort_req),
        .head_addr(bus_addr), .head_data(bus_data),
        .empty(q_empty), .full(q_full)
    );

    // datapath steering
    assign accept    = acc_valid && (ctl_q.phase == PH_IDLE) && !abort_req;
    assign local_hit = cls_private || sl_at_acc;
    assign q_push    = accept && acc_store && !local_hit && !q_full;
    assign sl_set    = accept && cls_private;
    assign sl_clr    = abort_req || (ctl_q.phase == PH_CLEAR);
    assign bus_valid = (ctl_q.phase == PH_DRAIN) && !q_empty;
    assign q_pop     = bus_valid && bus_ready && !abort_req;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        if (abort_req) begin
            ctl_d.phase = PH_IDLE;
            ctl_d.ovf   = 1'b0;
        end else begin
            if (accept && acc_store && !local_hit && q_full) ctl_d.ovf = 1'b1;
            unique case (ctl_q.phase)
                PH_IDLE:  if (commit_req) ctl_d.phase = PH_DRAIN;
                PH_DRAIN: if (q_empty)    ctl_d.phase = PH_CLEAR;
                PH_CLEAR: begin
                    ctl_d.phase = PH_IDLE;
                    ctl_d.ovf   = 1'b0;
                    ctl_d.done  = 1'b1;
                end
                default:  ctl_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{phase: PH_IDLE, ovf: 1'b0, done: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign acc_private = cls_private;
    assign commit_done = ctl_q.done;
    assign q_overflow  = ctl_q.ovf;

    // R2: a private store never reaches the log
    assert_private_unlogged_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_store && acc_private) |-> !q_push);

    // R6: a stalled replay keeps its payload
    assert_bus_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready && !abort_req) |=> (bus_valid && $stable(bus_addr) && $stable(bus_data)));

    // R8: completion is a single pulse with clean state
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_done |=> !commit_done);
    assert_done_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_done |-> (!sl_any && q_empty && !q_overflow));

    // R9: abort leaves nothing pending
    assert_abort_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> (q_empty && !sl_any && !q_overflow && !bus_valid));

    // R10: no access is taken while a commit runs
    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.phase != PH_IDLE) |-> (!q_push && !sl_set));

endmodule

// File: tb/txpf_store_filter_tb_top.sv
`timescale 1ns/1ps
module txpf_store_filter_tb_top;
    localparam int DEPTH = 8;
    localparam logic [31:0] LOC = 32'h0020_0000; // protection bit 21

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic win_we = 1'b0;
    logic [31:0] win_lo = '0, win_hi = '0;
    logic acc_valid = 1'b0, acc_store = 1'b0;
    logic [31:0] acc_addr = '0, acc_data = '0, acc_prot = '0;
    logic acc_private;
    logic [31:0] sl_probe_addr = '0;
    logic sl_probe;
    logic commit_req = 1'b0, abort_req = 1'b0;
    logic bus_valid, bus_ready = 1'b0;
    logic [31:0] bus_addr, bus_data;
    logic commit_done, q_overflow;

    always #2 clk = ~clk;

    txpf_store_filter dut_i (
        .clk(clk), .rst_n(rst_n),
        .win_we(win_we), .win_lo(win_lo), .win_hi(win_hi),
        .acc_valid(acc_valid), .acc_store(acc_store), .acc_addr(acc_addr),
        .acc_data(acc_data), .acc_prot(acc_prot), .acc_private(acc_private),
        .sl_probe_addr(sl_probe_addr), .sl_probe(sl_probe),
        .commit_req(commit_req), .abort_req(abort_req),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_ready(bus_ready), .commit_done(commit_done), .q_overflow(q_overflow)
    );

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    // requirement model
    bit sl_m [64];
    logic [31:0] ea [16];
    logic [31:0] ed [16];
    int en = 0;
    bit eovf = 1'b0;
    logic [31:0] wlo = '0, whi = '0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit priv_m(input logic [31:0] a, input logic [31:0] p);
        return p[21] || ((a[31:2] >= wlo[31:2]) && (a[31:2] < whi[31:2]));
    endfunction

    task automatic clear_model();
        for (int i = 0; i < 64; i++) sl_m[i] = 1'b0;
        en = 0;
        eovf = 1'b0;
    endtask

    task automatic set_window(input logic [31:0] lo, input logic [31:0] hi);
        @(negedge clk);
        win_we = 1'b1; win_lo = lo; win_hi = hi;
        @(negedge clk);
        win_we = 1'b0;
        wlo = lo; whi = hi;
    endtask

    task automatic access(input bit st, input logic [31:0] a, input logic [31:0] d,
                          input logic [31:0] p, input string req);
        bit pm, loc;
        @(negedge clk);
        acc_valid = 1'b1; acc_store = st; acc_addr = a; acc_data = d; acc_prot = p;
        #1;
        pm = priv_m(a, p);
        chk(req, "acc_private", {31'd0, acc_private}, {31'd0, pm});
        loc = pm || sl_m[a[7:2]];
        if (st && !loc) begin
            if (en < DEPTH) begin ea[en] = a; ed[en] = d; en++; end
            else eovf = 1'b1;
        end
        if (pm) sl_m[a[7:2]] = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic probe(input logic [31:0] a, input bit exp, input string req);
        sl_probe_addr = a;
        #1;
        chk(req, "sl_probe", {31'd0, sl_probe}, {31'd0, exp});
    endtask

    // stall: 0 ready always, 1 ready every other cycle, 2 ready from cycle 4
    task automatic commit(input int stall, input bit intrude, input string req);
        int got = 0;
        bit seen = 1'b0, prev_stall = 1'b0;
        logic [31:0] pa = '0, pd = '0;
        @(negedge clk); commit_req = 1'b1;
        @(negedge clk); commit_req = 1'b0;
        for (int c = 0; c < 200 && !seen; c++) begin
            bus_ready = (stall == 0) ? 1'b1 : (stall == 1) ? c[0] : (c >= 4);
            acc_valid = 1'b0;
            if (intrude && c == 1) begin
                acc_valid = 1'b1; acc_store = 1'b1; acc_addr = 32'h5000; acc_data = 32'hBAD0; acc_prot = '0;
            end
            if (intrude && c == 2) begin
                acc_valid = 1'b1; acc_store = 1'b0; acc_addr = 32'h5004; acc_prot = LOC;
            end
            #1;
            if (intrude && c == 3) probe(32'h5004, 1'b0, "R10");
            if (prev_stall) begin
                chk("R6", "held valid", {31'd0, bus_valid}, 32'd1);
                chk("R6", "held addr", bus_addr, pa);
                chk("R6", "held data", bus_data, pd);
            end
            if (bus_valid && bus_ready) begin
                if (got < en) begin
                    chk(req, "replay addr", bus_addr, ea[got]);
                    chk(req, "replay data", bus_data, ed[got]);
                end else begin
                    chk("R8", "unexpected transfer", bus_addr, 32'hFFFF_FFFF);
                end
                got++;
            end
            prev_stall = bus_valid && !bus_ready;
            pa = bus_addr; pd = bus_data;
            if (commit_done) seen = 1'b1;
            @(negedge clk);
        end
        acc_valid = 1'b0;
        bus_ready = 1'b0;
        chk("R8", "done seen", {31'd0, seen}, 32'd1);
        chk(req, "transfer count", got, en);
        #1;
        chk("R8", "done single pulse", {31'd0, commit_done}, 32'd0);
        chk("R8", "overflow after commit", {31'd0, q_overflow}, 32'd0);
        clear_model();
    endtask

    task automatic t_reset();
        chk("R1", "bus_valid", {31'd0, bus_valid}, 32'd0);
        chk("R1", "commit_done", {31'd0, commit_done}, 32'd0);
        chk("R1", "q_overflow", {31'd0, q_overflow}, 32'd0);
        probe(32'h2000, 1'b0, "R1");
        probe(32'h20FC, 1'b0, "R1");
    endtask

    task automatic t_page();
        set_window(32'h0, 32'h0);
        access(1'b1, 32'h2000, 32'h1111_AAAA, LOC, "R2");
        probe(32'h2000, 1'b1, "R2");
        access(1'b1, 32'h2004, 32'h2222_BBBB, 32'h0, "R4");
        probe(32'h2004, 1'b0, "R4");
        probe(32'h2008, 1'b0, "R4");
        probe(32'h2000, 1'b1, "R4");
        commit(0, 1'b0, "R2");
        probe(32'h2000, 1'b0, "R8");
    endtask

    task automatic t_window();
        set_window(32'h8000, 32'h8010);
        access(1'b1, 32'h7FFC, 32'h3000_0001, 32'h0, "R3");
        access(1'b1, 32'h8000, 32'h3000_0002, 32'h0, "R3");
        access(1'b1, 32'h800C, 32'h3000_0003, 32'h0, "R3");
        access(1'b1, 32'h8010, 32'h3000_0004, 32'h0, "R3");
        probe(32'h8000, 1'b1, "R3");
        probe(32'h8010, 1'b0, "R3");
        set_window(32'h9000, 32'h9008);
        access(1'b1, 32'h8004, 32'h3000_0005, 32'h0, "R3");
        commit(1, 1'b0, "R6");
        probe(32'h800C, 1'b0, "R8");
    endtask

    task automatic t_slword();
        access(1'b0, 32'h3008, 32'h0, LOC, "R5");
        access(1'b1, 32'h3008, 32'h4444_CCCC, 32'h0, "R5");
        access(1'b1, 32'h300C, 32'h5555_DDDD, 32'h0, "R5");
        commit(0, 1'b0, "R5");
    endtask

    task automatic t_overflow();
        for (int i = 0; i < DEPTH; i++)
            access(1'b1, 32'h4000 + 32'(4 * i), 32'hA000 + 32'(i), 32'h0, "R7");
        chk("R7", "overflow at full", {31'd0, q_overflow}, 32'd0);
        access(1'b1, 32'h4000 + 32'(4 * DEPTH), 32'hA0FF, 32'h0, "R7");
        chk("R7", "overflow flag", {31'd0, q_overflow}, 32'd1);
        access(1'b0, 32'h4100, 32'h0, 32'h0, "R7");
        chk("R7", "overflow sticky", {31'd0, q_overflow}, 32'd1);
        commit(0, 1'b0, "R7");
    endtask

    task automatic t_abort();
        access(1'b1, 32'h6040, 32'h6666_0000, LOC, "R9");
        for (int i = 0; i <= DEPTH; i++)
            access(1'b1, 32'h6000 + 32'(4 * i), 32'hB000 + 32'(i), 32'h0, "R9");
        chk("R9", "overflow before abort", {31'd0, q_overflow}, 32'd1);
        @(negedge clk); abort_req = 1'b1;
        @(negedge clk); abort_req = 1'b0;
        clear_model();
        #1;
        chk("R9", "overflow after abort", {31'd0, q_overflow}, 32'd0);
        chk("R9", "bus_valid after abort", {31'd0, bus_valid}, 32'd0);
        probe(32'h6040, 1'b0, "R9");
        commit(0, 1'b0, "R9");
    endtask

    task automatic t_busy();
        access(1'b1, 32'h7000, 32'h7777_EEEE, 32'h0, "R10");
        commit(2, 1'b1, "R10");
        commit(0, 1'b0, "R10");
    endtask

    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_page();
        t_window();
        t_slword();
        t_overflow();
        t_abort();
        t_busy();
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

endmodule